// File: doc/BRIEF.md
# Boot Image Descriptor Search Sequencer

This block is a hardware sequencer that looks for a loader image on block storage after reset and copies it into local RAM. Two straps are captured while reset is held: a 2-bit boot-select field that enables the storage-card path, and an active-low fast-boot strap. When the fast strap is low, a window of 24 blocks starting at block 25 is searched for a descriptor with the fast tag. If none is found, the normal window of 24 blocks starting at block 0 is searched for the normal magic word.

The storage port is an abstract stream. A one-cycle `rdReq` names a block on `rdBlock`. The storage then returns that block's words on `rdData` with `rdValid`, and raises `crcErr` with any word it could not read cleanly. Word 0 of a block is the magic word, word 1 is the image length in 32-bit words, and the image follows. A good image is written into RAM at byte offset 0x20. The 1-based position of the winning block within its window is then written to the last word of RAM, and `done` pulses once together with the entry address.

When every block of the normal window fails, `status` starts to toggle at 4 Hz, derived from `CLK_HZ`. The sequence then starts again from its first window. The toggling ends, with `status` low, once an image has been loaded.

Top module: `bootSearchSeq`

## Requirements
- R1: The boot-select field and fast strap are captured only while `rstN` is low. Unless the field was binary 10, the sequencer stays idle: it issues no `rdReq`, keeps `busy` low and never pulses `done`. Changing the straps after reset has no effect.
- R2: With the fast strap low, the first block requested is 25. With it high, the first block requested is 0.
- R3: In the fast window a magic word is accepted when bits 31:8 equal 0xF1FCED, whatever bits 7:0 hold. Any other value, including the normal magic, is rejected there.
- R4: In the normal window only the full 32-bit `NORM_MAGIC` (default 0x5EEDB007) is accepted. A block that fails moves the search to the next consecutive block, and no more than 24 blocks (0 to 23) are examined per pass.
- R5: When all fast-window blocks 25 to 48 fail, the next block requested is 0 and the normal window is searched.
- R6: The length in word 1 must lie in 1 to 7680 (a 30 KB image). A length of 0 or above 7680 makes the block fail with no image writes.
- R7: Image word i (the block's word i+2) is written to byte address 0x20 + 4*i. Every RAM write lands in the image window or at the index word.
- R8: If `crcErr` is high with any word read for a block (magic, length or image), that block is abandoned at once: that word and the rest of the block are not written, and the following block is requested next.
- R9: After a complete copy, the block's 1-based position within its window (1 to 24) is written to byte address `RAM_BYTES`-4 (0x7FFC).
- R10: `busy` is high from reset release until the cycle in which `done` pulses for exactly one cycle with `entryAddr` = 0x20. No further requests follow.
- R11: After a full normal-window failure, `status` toggles every `CLK_HZ`/8 cycles and the search restarts from its first block. After `done`, `status` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are captured while low |
| bootSel | input | 2 | Boot-select strap field; 2'b10 enables the sequencer |
| fastStrap | input | 1 | Fast-boot strap, low selects the fast window first |
| rdReq | output | 1 | One-cycle read request for block `rdBlock` |
| rdBlock | output | BLK_W | Block number being requested |
| rdValid | input | 1 | Storage word valid |
| rdData | input | 32 | Storage word |
| crcErr | input | 1 | Read error flag, accompanying a word |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | log2(RAM_BYTES) | RAM byte address |
| ramWdata | output | 32 | RAM write data |
| busy | output | 1 | Search/copy in progress |
| done | output | 1 | One-cycle pulse after a successful load |
| entryAddr | output | log2(RAM_BYTES) | Image start address, valid with `done` |
| status | output | 1 | 4 Hz toggling failure indicator |

## Verification
The hardest situation to reach from the ports is a complete failed pass followed by a restart and a late success. This exercises the blink divider, the restart block and the blink shutdown together. The bench shrinks `CLK_HZ` so that the half-period is ten cycles, and leaves every block empty until several toggles have been timed and a second pass has begun. It then writes a good descriptor into a mid-window block of its storage model while the sequencer runs. The CRC abort case is driven by flagging one chosen word index per block, so that an abort can be placed during the length word and during the image.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_REQ,
    S_MAGIC,
    S_LEN,
    S_COPY,
    S_INDEX,
    S_NEXT,
    S_DONE,
    S_HALT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPos;
    logic incPos;
    logic setFast;
    logic setNorm;
    logic ldLen;
    logic wrImg;
    logic wrIdx;
    logic blinkOn;
    logic blinkOff;
  } seqCmd_t;

endpackage

// File: rtl/bssCtrl.sv
module bssCtrl
  import bss_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pathEn,
  input  logic    fastSel,
  input  logic    rdValid,
  input  logic    crcErr,
  input  logic    posLast,
  input  logic    magicOk,
  input  logic    lenOk,
  input  logic    copyLast,
  input  logic    inFast,
  output seqCmd_t cmd,
  output logic    rdReq,
  output logic    busy,
  output logic    done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    rdReq     = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_OFF: begin
        if (pathEn) begin
          cmd.clrPos = 1'b1;
          if (fastSel) cmd.setFast = 1'b1;
          else         cmd.setNorm = 1'b1;
          nextState = S_REQ;
        end
      end
      S_REQ: begin
        rdReq     = 1'b1;
        nextState = S_MAGIC;
      end
      S_MAGIC: begin
        if (crcErr)       nextState = S_NEXT;
        else if (rdValid) nextState = magicOk ? S_LEN : S_NEXT;
      end
      S_LEN: begin
        if (crcErr) nextState = S_NEXT;
        else if (rdValid) begin
          if (lenOk) begin
            cmd.ldLen = 1'b1;
            nextState = S_COPY;
          end else begin
            nextState = S_NEXT;
          end
        end
      end
      S_COPY: begin
        if (crcErr) nextState = S_NEXT;
        else if (rdValid) begin
          cmd.wrImg = 1'b1;
          if (copyLast) nextState = S_INDEX;
        end
      end
      S_INDEX: begin
        cmd.wrIdx = 1'b1;
        nextState = S_DONE;
      end
      S_NEXT: begin
        nextState = S_REQ;
        if (!posLast) begin
          cmd.incPos = 1'b1;
        end else if (inFast) begin
          cmd.clrPos  = 1'b1;
          cmd.setNorm = 1'b1;
        end else begin
          cmd.clrPos  = 1'b1;
          cmd.blinkOn = 1'b1;
          if (fastSel) cmd.setFast = 1'b1;
          else         cmd.setNorm = 1'b1;
        end
      end
      S_DONE: begin
        done         = 1'b1;
        cmd.blinkOff = 1'b1;
        nextState    = S_HALT;
      end
      S_HALT: nextState = S_HALT;
      default: nextState = S_OFF;
    endcase
  end

  always_comb begin
    busy = 1'b0;
    case (state)
      S_OFF:                                            busy = pathEn;
      S_REQ, S_MAGIC, S_LEN, S_COPY, S_INDEX, S_NEXT:   busy = 1'b1;
      default:                                          busy = 1'b0;
    endcase
  end

endmodule

// File: rtl/bssDatapath.sv
module bssDatapath
  import bss_pkg::*;
#(
  parameter int          BLK_W         = 8,
  parameter int          RAM_BYTES     = 32768,
  parameter int          IMG_BASE      = 32,
  parameter int          IMG_MAX_BYTES = 30720,
  parameter int          SEARCH_LEN    = 24,
  parameter int          FAST_BASE     = 25,
  parameter int          NORM_BASE     = 0,
  parameter logic [31:0] NORM_MAGIC    = 32'h5EED_B007,
  parameter logic [23:0] FAST_TAG      = 24'hF1FCED,
  parameter int          CLK_HZ        = 100_000_000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqCmd_t                      cmd,
  input  logic [31:0]                  rdData,
  output logic [BLK_W-1:0]             rdBlock,
  output logic                         posLast,
  output logic                         magicOk,
  output logic                         lenOk,
  output logic                         copyLast,
  output logic                         inFast,
  output logic                         ramWe,
  output logic [$clog2(RAM_BYTES)-1:0] ramAddr,
  output logic [31:0]                  ramWdata,
  output logic                         status
);

  localparam int AW        = $clog2(RAM_BYTES);
  localparam int MAX_WORDS = IMG_MAX_BYTES / 4;
  localparam int LW        = $clog2(MAX_WORDS + 1);
  localparam int PW        = $clog2(SEARCH_LEN + 1);
  localparam int HALF      = (CLK_HZ / 8 < 1) ? 1 : CLK_HZ / 8;
  localparam int CW        = $clog2(HALF + 1);

  logic [PW-1:0] pos;
  logic [LW-1:0] lenQ;
  logic [LW-1:0] wordCnt;
  logic          blinkEn;

  // search position and window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos    <= '0;
      inFast <= 1'b0;
    end else begin
      if (cmd.clrPos)      pos <= '0;
      else if (cmd.incPos) pos <= pos + PW'(1);
      if (cmd.setFast)      inFast <= 1'b1;
      else if (cmd.setNorm) inFast <= 1'b0;
    end
  end

  assign rdBlock = (inFast ? BLK_W'(FAST_BASE) : BLK_W'(NORM_BASE)) + BLK_W'(pos);
  assign posLast = (pos == PW'(SEARCH_LEN - 1));

  // descriptor decode
  assign magicOk  = inFast ? (rdData[31:8] == FAST_TAG) : (rdData == NORM_MAGIC);
  assign lenOk    = (rdData != 32'd0) && (rdData <= 32'(MAX_WORDS));
  assign copyLast = (wordCnt == (lenQ - LW'(1)));

  // length and copy counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ    <= '0;
      wordCnt <= '0;
    end else if (cmd.ldLen) begin
      lenQ    <= rdData[LW-1:0];
      wordCnt <= '0;
    end else if (cmd.wrImg) begin
      wordCnt <= wordCnt + LW'(1);
    end
  end

  // registered RAM write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramWdata <= '0;
    end else begin
      ramWe <= cmd.wrImg | cmd.wrIdx;
      if (cmd.wrImg) begin
        ramAddr  <= AW'(IMG_BASE) + (AW'(wordCnt) << 2);
        ramWdata <= rdData;
      end else if (cmd.wrIdx) begin
        ramAddr  <= AW'(RAM_BYTES - 4);
        ramWdata <= 32'(pos) + 32'd1;
      end
    end
  end

  // failure indicator divider
  always_ff @(posedge clk) begin
    if (!rstN)             blinkEn <= 1'b0;
    else if (cmd.blinkOff) blinkEn <= 1'b0;
    else if (cmd.blinkOn)  blinkEn <= 1'b1;
  end

  generate
    if (HALF == 1) begin : g_fastToggle
      always_ff @(posedge clk) begin
        if (!rstN || cmd.blinkOff) status <= 1'b0;
        else if (blinkEn)          status <= ~status;
      end
    end else begin : g_divToggle
      logic [CW-1:0] blinkCnt;
      always_ff @(posedge clk) begin
        if (!rstN || cmd.blinkOff) begin
          blinkCnt <= '0;
          status   <= 1'b0;
        end else if (blinkEn) begin
          if (blinkCnt == CW'(HALF - 1)) begin
            blinkCnt <= '0;
            status   <= ~status;
          end else begin
            blinkCnt <= blinkCnt + CW'(1);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bootSearchSeq.sv
module bootSearchSeq
  import bss_pkg::*;
#(
  parameter int          BLK_W         = 8,
  parameter int          RAM_BYTES     = 32768,
  parameter int          IMG_BASE      = 32,
  parameter int          IMG_MAX_BYTES = 30720,
  parameter int          SEARCH_LEN    = 24,
  parameter int          FAST_BASE     = 25,
  parameter int          NORM_BASE     = 0,
  parameter logic [31:0] NORM_MAGIC    = 32'h5EED_B007,
  parameter logic [23:0] FAST_TAG      = 24'hF1FCED,
  parameter int          CLK_HZ        = 100_000_000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   bootSel,
  input  logic                         fastStrap,
  output logic                         rdReq,
  output logic [BLK_W-1:0]             rdBlock,
  input  logic                         rdValid,
  input  logic [31:0]                  rdData,
  input  logic                         crcErr,
  output logic                         ramWe,
  output logic [$clog2(RAM_BYTES)-1:0] ramAddr,
  output logic [31:0]                  ramWdata,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(RAM_BYTES)-1:0] entryAddr,
  output logic                         status
);

  localparam int AW = $clog2(RAM_BYTES);

  logic [1:0] selQ;
  logic       fastQ;
  logic       pathEn;
  seqCmd_t    cmd;
  logic       posLast, magicOk, lenOk, copyLast, inFast;

  // straps are captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= bootSel;
      fastQ <= ~fastStrap;
    end
  end

  assign pathEn    = (selQ == 2'b10);
  assign entryAddr = AW'(IMG_BASE);

  bssCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pathEn   (pathEn),
    .fastSel  (fastQ),
    .rdValid  (rdValid),
    .crcErr   (crcErr),
    .posLast  (posLast),
    .magicOk  (magicOk),
    .lenOk    (lenOk),
    .copyLast (copyLast),
    .inFast   (inFast),
    .cmd      (cmd),
    .rdReq    (rdReq),
    .busy     (busy),
    .done     (done)
  );

  bssDatapath #(
    .BLK_W         (BLK_W),
    .RAM_BYTES     (RAM_BYTES),
    .IMG_BASE      (IMG_BASE),
    .IMG_MAX_BYTES (IMG_MAX_BYTES),
    .SEARCH_LEN    (SEARCH_LEN),
    .FAST_BASE     (FAST_BASE),
    .NORM_BASE     (NORM_BASE),
    .NORM_MAGIC    (NORM_MAGIC),
    .FAST_TAG      (FAST_TAG),
    .CLK_HZ        (CLK_HZ)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .rdData   (rdData),
    .rdBlock  (rdBlock),
    .posLast  (posLast),
    .magicOk  (magicOk),
    .lenOk    (lenOk),
    .copyLast (copyLast),
    .inFast   (inFast),
    .ramWe    (ramWe),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .status   (status)
  );

endmodule

// File: rtl/bssChecker.sv
module bssChecker #(
  parameter int BLK_W         = 8,
  parameter int RAM_BYTES     = 32768,
  parameter int IMG_BASE      = 32,
  parameter int IMG_MAX_BYTES = 30720,
  parameter int SEARCH_LEN    = 24,
  parameter int FAST_BASE     = 25,
  parameter int NORM_BASE     = 0
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         pathEn,
  input logic                         rdReq,
  input logic [BLK_W-1:0]             rdBlock,
  input logic                         ramWe,
  input logic [$clog2(RAM_BYTES)-1:0] ramAddr,
  input logic                         busy,
  input logic                         done,
  input logic [$clog2(RAM_BYTES)-1:0] entryAddr,
  input logic                         status
);

  localparam int AW = $clog2(RAM_BYTES);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pathEn |-> (!rdReq && !busy && !done)); // R1

  AST_BLOCK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ((rdBlock >= BLK_W'(NORM_BASE) && rdBlock < BLK_W'(NORM_BASE + SEARCH_LEN)) ||
               (rdBlock >= BLK_W'(FAST_BASE) && rdBlock < BLK_W'(FAST_BASE + SEARCH_LEN)))); // R4

  AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ((ramAddr >= AW'(IMG_BASE) && ramAddr < AW'(IMG_BASE + IMG_MAX_BYTES)) ||
               ramAddr == AW'(RAM_BYTES - 4))); // R7

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy); // R10

  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (entryAddr == AW'(IMG_BASE) && !busy)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy && !rdReq)); // R10

  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !status); // R11

endmodule

bind bootSearchSeq bssChecker #(
  .BLK_W         (BLK_W),
  .RAM_BYTES     (RAM_BYTES),
  .IMG_BASE      (IMG_BASE),
  .IMG_MAX_BYTES (IMG_MAX_BYTES),
  .SEARCH_LEN    (SEARCH_LEN),
  .FAST_BASE     (FAST_BASE),
  .NORM_BASE     (NORM_BASE)
) i_bssChecker (
  .clk       (clk),
  .rstN      (rstN),
  .pathEn    (pathEn),
  .rdReq     (rdReq),
  .rdBlock   (rdBlock),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .busy      (busy),
  .done      (done),
  .entryAddr (entryAddr),
  .status    (status)
);

// File: tb/test_bootSearchSeq.sv
`timescale 1ns/1ps
module test_bootSearchSeq;

  localparam int          BLK_W     = 8;
  localparam int          RAM_BYTES = 32768;
  localparam int          AW        = 15;
  localparam int          CLK_HZ    = 80;          // half period of 10 cycles
  localparam logic [31:0] NMAGIC    = 32'h5EED_B007;
  localparam int          WD_LIMIT  = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        bootSel = 2'b00;
  logic              fastStrap = 1'b1;
  logic              rdReq;
  logic [BLK_W-1:0]  rdBlock;
  logic              rdValid = 1'b0;
  logic [31:0]       rdData = '0;
  logic              crcErr = 1'b0;
  logic              ramWe;
  logic [AW-1:0]     ramAddr;
  logic [31:0]       ramWdata;
  logic              busy, done, status;
  logic [AW-1:0]     entryAddr;

  always #5 clk = ~clk;

  bootSearchSeq #(.CLK_HZ(CLK_HZ)) i_bootSearchSeq (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .fastStrap(fastStrap),
    .rdReq(rdReq), .rdBlock(rdBlock), .rdValid(rdValid), .rdData(rdData),
    .crcErr(crcErr), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .busy(busy), .done(done), .entryAddr(entryAddr), .status(status)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // storage model contents
  logic [31:0] bMagic [64];
  logic [31:0] bLen   [64];
  int          bCrc   [64];

  function automatic logic [31:0] wordOf(input int blk, input int idx);
    if (idx == 0)      return bMagic[blk];
    else if (idx == 1) return bLen[blk];
    else               return {8'(blk), 8'hA5, 16'(idx - 2)};
  endfunction

  // logs
  int          reqLog [256];
  int          reqN;
  logic [31:0] imgMem [16];
  logic [31:0] idxWord;
  int          imgWrites, outsideWr, lastImgAddr;
  int          blkWr [64];
  int          doneCnt;
  int          entryAtDone;
  int          togLog [8];
  int          togN;
  logic        statusPrev;

  int  curBlk, widx;
  bit  act;

  // storage stream model, driven away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      act <= 1'b0; rdValid <= 1'b0; crcErr <= 1'b0;
    end else if (rdReq) begin
      act <= 1'b1; curBlk <= int'(rdBlock); widx <= 0;
      rdValid <= 1'b0; crcErr <= 1'b0;
      if (reqN < 256) reqLog[reqN] = int'(rdBlock);
      reqN = reqN + 1;
    end else if (act) begin
      rdValid <= 1'b1;
      rdData  <= wordOf(curBlk, widx);
      crcErr  <= (widx == bCrc[curBlk]);
      widx    <= widx + 1;
    end
  end

  // RAM model
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rstN && ramWe) begin
      if (int'(ramAddr) == RAM_BYTES - 4) idxWord = ramWdata;
      else if (int'(ramAddr) >= 32 && int'(ramAddr) < 32 + 30720) begin
        if ((int'(ramAddr) - 32) / 4 < 16) imgMem[(int'(ramAddr) - 32) / 4] = ramWdata;
        imgWrites = imgWrites + 1;
        lastImgAddr = int'(ramAddr);
        if (int'(ramWdata[31:24]) < 64) blkWr[ramWdata[31:24]] = blkWr[ramWdata[31:24]] + 1;
      end else outsideWr = outsideWr + 1;
    end
  end

  // done and status monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin doneCnt = doneCnt + 1; entryAtDone = int'(entryAddr); end
      if (status !== statusPrev) begin
        if (togN < 8) togLog[togN] = cyc;
        togN = togN + 1;
      end
    end
    statusPrev = status;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic clearBlocks();
    for (int i = 0; i < 64; i++) begin
      bMagic[i] = 32'h0; bLen[i] = 32'h0; bCrc[i] = -1;
    end
  endtask

  task automatic startRun(input logic [1:0] sel, input logic strap);
    @(negedge clk);
    rstN = 1'b0; bootSel = sel; fastStrap = strap;
    repeat (3) @(negedge clk);
    reqN = 0; imgWrites = 0; outsideWr = 0; lastImgAddr = 0; doneCnt = 0;
    entryAtDone = 0; togN = 0; idxWord = 32'hDEAD_DEAD;
    for (int i = 0; i < 16; i++) imgMem[i] = 32'h0;
    for (int i = 0; i < 64; i++) blkWr[i] = 0;
    rstN = 1'b1;
  endtask

  task automatic waitDone(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (doneCnt > 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // reset state and disabled path
  task automatic tOff();
    clearBlocks();
    bMagic[0] = NMAGIC; bLen[0] = 32'd2;
    @(negedge clk);
    rstN = 1'b0; bootSel = 2'b01;
    repeat (3) @(negedge clk);
    chk(!busy && !rdReq && !ramWe && !done && !status, "R10", "reset state outputs",
        {busy, rdReq, ramWe, done, status}, 0);
    startRun(2'b01, 1'b1);
    bootSel = 2'b10;                 // late change must be ignored
    repeat (60) @(negedge clk);
    chk(reqN == 0, "R1", "requests with boot-select 01", reqN, 0);
    chk(!busy && doneCnt == 0, "R1", "busy/done while idle", {busy, 8'(doneCnt)}, 0);
  endtask

  // normal search: bad block 0, good block 1
  task automatic tNormal();
    clearBlocks();
    bMagic[0] = 32'h5EED_B006; bLen[0] = 32'd4;
    bMagic[1] = NMAGIC;        bLen[1] = 32'd4;
    startRun(2'b10, 1'b1);
    bootSel = 2'b00; fastStrap = 1'b0;  // straps ignored after reset
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R10", "busy after release", busy, 1);
    waitDone(2000);
    chk(reqN == 2 && reqLog[0] == 0, "R2", "first block normal path", reqLog[0], 0);
    chk(reqLog[1] == 1, "R4", "next block after magic miss", reqLog[1], 1);
    for (int i = 0; i < 4; i++)
      chk(imgMem[i] == wordOf(1, i + 2), "R7", "image word", imgMem[i], wordOf(1, i + 2));
    chk(imgWrites == 4 && outsideWr == 0, "R7", "image write count", imgWrites, 4);
    chk(idxWord == 32'd2, "R9", "index word", idxWord, 2);
    chk(doneCnt == 1 && entryAtDone == 32, "R10", "done pulse/entry", entryAtDone, 32);
    chk(!busy && !status, "R10", "busy after done", busy, 0);
  endtask

  // fast window with near misses
  task automatic tFast();
    clearBlocks();
    bMagic[25] = NMAGIC;        bLen[25] = 32'd3;
    bMagic[26] = 32'hF1FC_EC11; bLen[26] = 32'd3;
    bMagic[27] = 32'hF1FC_ED5A; bLen[27] = 32'd3;
    bMagic[0]  = NMAGIC;        bLen[0]  = 32'd3;
    startRun(2'b10, 1'b0);
    waitDone(2000);
    chk(reqLog[0] == 25, "R2", "first block fast path", reqLog[0], 25);
    chk(reqN == 3, "R3", "blocks tried in fast window", reqN, 3);
    chk(imgMem[0] == wordOf(27, 2), "R3", "fast image source", imgMem[0], wordOf(27, 2));
    chk(idxWord == 32'd3, "R9", "fast index word", idxWord, 3);
  endtask

  // fast window empty, fallback to normal
  task automatic tFallback();
    clearBlocks();
    bMagic[0] = NMAGIC; bLen[0] = 32'd2;
    startRun(2'b10, 1'b0);
    waitDone(3000);
    chk(reqN == 25, "R5", "requests before fallback success", reqN, 25);
    chk(reqLog[23] == 48, "R5", "last fast block", reqLog[23], 48);
    chk(reqLog[24] == 0, "R5", "fallback first block", reqLog[24], 0);
    chk(idxWord == 32'd1, "R9", "fallback index", idxWord, 1);
  endtask

  // CRC aborts in image and in length word
  task automatic tCrc();
    clearBlocks();
    bMagic[0] = NMAGIC; bLen[0] = 32'd4; bCrc[0] = 3;
    bMagic[1] = NMAGIC; bLen[1] = 32'd4; bCrc[1] = 1;
    bMagic[2] = NMAGIC; bLen[2] = 32'd3;
    startRun(2'b10, 1'b1);
    waitDone(2000);
    chk(reqN == 3 && reqLog[1] == 1 && reqLog[2] == 2, "R8", "resume after CRC", reqN, 3);
    chk(blkWr[0] == 1, "R8", "block 0 writes stop at error", blkWr[0], 1);
    chk(blkWr[1] == 0, "R8", "block 1 aborted at length", blkWr[1], 0);
    chk(blkWr[2] == 3 && imgMem[0] == wordOf(2, 2), "R8", "good copy after CRC", blkWr[2], 3);
    chk(idxWord == 32'd3, "R9", "index after CRC retries", idxWord, 3);
  endtask

  // length bounds, including the largest image
  task automatic tLen();
    clearBlocks();
    bMagic[0] = NMAGIC; bLen[0] = 32'd0;
    bMagic[1] = NMAGIC; bLen[1] = 32'd7681;
    bMagic[2] = NMAGIC; bLen[2] = 32'd7680;
    startRun(2'b10, 1'b1);
    waitDone(20000);
    chk(blkWr[0] == 0 && blkWr[1] == 0, "R6", "bad lengths skipped", blkWr[0] + blkWr[1], 0);
    chk(imgWrites == 7680, "R6", "max length copied", imgWrites, 7680);
    chk(lastImgAddr == 32'h781C, "R7", "last image address", lastImgAddr, 32'h781C);
    chk(idxWord == 32'd3, "R9", "index after length skips", idxWord, 3);
  endtask

  // total failure, blink, restart, late success
  task automatic tFail();
    clearBlocks();
    startRun(2'b10, 1'b1);
    for (int i = 0; i < 2000; i++) begin
      if (togN >= 3 && reqN > 30) break;
      @(negedge clk);
    end
    chk(togN >= 3, "R11", "status toggles", togN, 3);
    chk(togLog[1] - togLog[0] == 10, "R11", "half period 1", togLog[1] - togLog[0], 10);
    chk(togLog[2] - togLog[1] == 10, "R11", "half period 2", togLog[2] - togLog[1], 10);
    chk(reqLog[23] == 23 && reqLog[24] == 0, "R11", "restart from first block", reqLog[24], 0);
    @(posedge clk);
    bMagic[5] = NMAGIC; bLen[5] = 32'd2;
    waitDone(3000);
    chk(doneCnt == 1 && idxWord == 32'd6, "R9", "index after restart", idxWord, 6);
    repeat (25) @(negedge clk);
    chk(status == 1'b0, "R11", "status low after done", status, 0);
  endtask

  initial begin
    clearBlocks();
    reqN = 0; togN = 0; doneCnt = 0; statusPrev = 1'b0;
    tOff();
    tNormal();
    tFast();
    tFallback();
    tCrc();
    tLen();
    tFail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule